// File: doc/BRIEF.md
# Performance event to counter mapper

This block keeps the bindings between a small set of hardware event identifiers and the programmable performance counters of a core. Software binds an event by writing a selector value together with a counter number. The block accepts the write only if the counter number refers to a programmable counter that is present. A nonzero selector must also name one of the supported events. A zero selector releases every binding that targets the given counter. Rejected writes raise a one-cycle error pulse.

Event sources present a 20-bit event index on the lookup port. The block answers in the same cycle with a hit flag and the bound counter number, or with a miss. The index has a 4-bit type field in bits [19:16] and a 16-bit code in bits [15:0]. Cache-class codes split into a cache id in bits [15:3], an operation in bits [2:1] and a result in bit [0]. The availability mask is a static configuration input, and the block checks that it is legal.

Top module: `evt_ctr_map`

## Requirements
- R1: Five event indices are supported: 0x00001 (core cycles), 0x00002 (retired instructions), 0x10019 (data TLB read miss), 0x1001B (data TLB write miss), 0x10021 (instruction TLB miss). A write whose nonzero selector carries any other index in bits [19:0] is rejected.
- R2: A write is accepted only when its counter number is at least 3, below NUM_CTR, and has its bit set in the availability mask. Any other write is rejected and leaves every binding unchanged.
- R3: An accepted write of a supported event to a valid counter binds that event. From the cycle after the write edge, a lookup of the event returns hit with that counter number. Bindings then hold until they are removed or reset.
- R4: A write of an event that is already bound is accepted without error and keeps the existing counter. The first binding wins.
- R5: A write of selector value zero to a valid counter removes every binding that points at that counter and leaves all other bindings in place. It raises no error, including when nothing was bound.
- R6: Selector bits above bit 19 do not affect which event is named. A selector that is nonzero only above bit 19 names index 0 and is rejected.
- R7: `wr_err` is high for exactly the one cycle that follows each rejected write and is low at all other times.
- R8: `cfg_err` is high when any of mask bits 0 to 2 is set, or when the mask has more than NUM_CTR-3 bits set. While it is high, the block treats the mask as zero.
- R9: While the effective availability mask is zero, every lookup misses. Stored bindings are kept and are returned again once the mask is nonzero.
- R10: Reset clears all bindings, so every lookup misses and `wr_err` is low.
- R11: A lookup of an index outside the supported set always misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| avail_mask | input | NUM_CTR | Counters present; bit n set means counter n exists |
| cfg_err | output | 1 | Availability mask is illegal |
| wr_en | input | 1 | Configuration write strobe |
| wr_ctr | input | CTR_W | Counter number of the write |
| wr_sel | input | SEL_W | Event selector value; bits [19:0] name the event |
| wr_err | output | 1 | Registered pulse after a rejected write |
| lk_evt | input | 20 | Event index presented by an event source |
| lk_hit | output | 1 | Lookup found a binding |
| lk_ctr | output | CTR_W | Bound counter number, zero on a miss |

## Verification
The hardest state to reach is a counter that holds several bindings at once, followed by a zero write that has to release all of them and leave a different counter's binding intact. The vector table binds both data TLB events to one counter and the instruction TLB event to another. It then clears the first counter and walks lookups across all three events. A second hard case is bindings that are hidden by a zero or illegal mask but still stored. The directed tests show these bindings disappearing and then coming back when the mask is restored.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int EVT_W   = 20;
  localparam int NUM_EVT = 5;

  // cache-class code: {cache id[12:0], operation[1:0], result}
  function automatic logic [EVT_W-1:0] cache_evt(input logic [12:0] id,
                                                 input logic [1:0]  op,
                                                 input logic        res);
    return {4'h1, id, op, res};
  endfunction

  localparam logic [EVT_W-1:0] EV_CYCLES  = 20'h00001;
  localparam logic [EVT_W-1:0] EV_INSTR   = 20'h00002;
  localparam logic [EVT_W-1:0] EV_DTLB_RD = cache_evt(13'd3, 2'd0, 1'b1);
  localparam logic [EVT_W-1:0] EV_DTLB_WR = cache_evt(13'd3, 2'd1, 1'b1);
  localparam logic [EVT_W-1:0] EV_ITLB    = cache_evt(13'd4, 2'd0, 1'b1);

  // slot order of the binding table
  function automatic logic [NUM_EVT-1:0] evt_onehot(input logic [EVT_W-1:0] e);
    logic [NUM_EVT-1:0] oh;
    oh = '0;
    case (e)
      EV_CYCLES:  oh[0] = 1'b1;
      EV_INSTR:   oh[1] = 1'b1;
      EV_DTLB_RD: oh[2] = 1'b1;
      EV_DTLB_WR: oh[3] = 1'b1;
      EV_ITLB:    oh[4] = 1'b1;
      default:    oh    = '0;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/pmap_decode.sv
module pmap_decode
  import pmap_pkg::*;
(
  input  logic [EVT_W-1:0]   evt,
  output logic [NUM_EVT-1:0] slot_oh,
  output logic               known
);
  always_comb begin
    slot_oh = evt_onehot(evt);
    known   = |slot_oh;
  end
endmodule

// File: rtl/pmap_cfg_check.sv
module pmap_cfg_check #(
  parameter int NUM_CTR    = 32,
  parameter int FIRST_PROG = 3
) (
  input  logic [NUM_CTR-1:0] avail_mask,
  output logic               cfg_err,
  output logic [NUM_CTR-1:0] eff_mask
);
  localparam int CNT_W = $clog2(NUM_CTR + 1);
  localparam logic [CNT_W-1:0] MAX_PROG = CNT_W'(NUM_CTR - FIRST_PROG);

  logic [CNT_W-1:0] pop;
  logic             low_set;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      pop = pop + CNT_W'(avail_mask[i]);
    end
    low_set  = |avail_mask[FIRST_PROG-1:0];
    cfg_err  = low_set || (pop > MAX_PROG);
    eff_mask = cfg_err ? '0 : avail_mask;
  end
endmodule

// File: rtl/pmap_entry.sv
module pmap_entry #(
  parameter int CTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [CTR_W-1:0] set_ctr,
  input  logic             clr_en,
  output logic             vld,
  output logic [CTR_W-1:0] ctr
);
  logic             upd;
  logic             vld_d;
  logic [CTR_W-1:0] ctr_d;

  always_comb begin
    upd   = set_en || clr_en;
    vld_d = vld;
    ctr_d = ctr;
    if (set_en) begin
      vld_d = 1'b1;
      ctr_d = set_ctr;
    end else if (clr_en) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      ctr <= '0;
    end else if (upd) begin
      vld <= vld_d;
      ctr <= ctr_d;
    end
  end
endmodule

// File: rtl/evt_ctr_map.sv
module evt_ctr_map
  import pmap_pkg::*;
#(
  parameter int NUM_CTR    = 32,
  parameter int SEL_W      = 32,
  parameter int FIRST_PROG = 3,
  localparam int CTR_W     = $clog2(NUM_CTR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] avail_mask,
  output logic               cfg_err,
  input  logic               wr_en,
  input  logic [CTR_W-1:0]   wr_ctr,
  input  logic [SEL_W-1:0]   wr_sel,
  output logic               wr_err,
  input  logic [EVT_W-1:0]   lk_evt,
  output logic               lk_hit,
  output logic [CTR_W-1:0]   lk_ctr
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // availability mask
  logic [NUM_CTR-1:0] eff_mask;
  logic               any_avail;

  pmap_cfg_check #(.NUM_CTR(NUM_CTR), .FIRST_PROG(FIRST_PROG)) u_cfg (
    .avail_mask (avail_mask),
    .cfg_err    (cfg_err),
    .eff_mask   (eff_mask)
  );
  assign any_avail = |eff_mask;

  // write path
  logic [NUM_EVT-1:0] wr_oh;
  logic               wr_known;
  logic               ctr_ok;
  logic               sel_nz;
  logic               wr_go;
  logic               err_d;

  pmap_decode u_wr_dec (
    .evt     (wr_sel[EVT_W-1:0]),
    .slot_oh (wr_oh),
    .known   (wr_known)
  );

  always_comb begin
    ctr_ok = (wr_ctr >= CTR_W'(FIRST_PROG)) &&
             ({1'b0, wr_ctr} < (CTR_W+1)'(NUM_CTR)) &&
             eff_mask[wr_ctr];
    sel_nz = |wr_sel;
    wr_go  = wr_en && ctr_ok;
    err_d  = wr_en && (!ctr_ok || (sel_nz && !wr_known));
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) wr_err <= 1'b0;
    else          wr_err <= err_d;
  end

  // binding table, one entry per supported event
  logic [NUM_EVT-1:0] slot_vld;
  logic [CTR_W-1:0]   slot_ctr [NUM_EVT];
  logic [NUM_EVT-1:0] set_en;
  logic [NUM_EVT-1:0] clr_en;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_slot
    assign set_en[g] = wr_go && sel_nz && wr_oh[g] && !slot_vld[g];
    assign clr_en[g] = wr_go && !sel_nz && slot_vld[g] && (slot_ctr[g] == wr_ctr);

    pmap_entry #(.CTR_W(CTR_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .set_en  (set_en[g]),
      .set_ctr (wr_ctr),
      .clr_en  (clr_en[g]),
      .vld     (slot_vld[g]),
      .ctr     (slot_ctr[g])
    );
  end

  // lookup path
  logic [NUM_EVT-1:0] lk_oh;
  logic               lk_known;
  logic [NUM_EVT-1:0] lk_sel;

  pmap_decode u_lk_dec (
    .evt     (lk_evt),
    .slot_oh (lk_oh),
    .known   (lk_known)
  );

  always_comb begin
    lk_sel = (lk_known && any_avail) ? (lk_oh & slot_vld) : '0;
    lk_hit = |lk_sel;
    lk_ctr = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      lk_ctr = lk_ctr | (lk_sel[i] ? slot_ctr[i] : '0);
    end
  end
endmodule

// File: rtl/evt_ctr_map_chk.sv
module evt_ctr_map_chk
  import pmap_pkg::*;
#(
  parameter int NUM_CTR    = 32,
  parameter int SEL_W      = 32,
  parameter int FIRST_PROG = 3,
  localparam int CTR_W     = $clog2(NUM_CTR)
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic [NUM_CTR-1:0] avail_mask,
  input logic               cfg_err,
  input logic               wr_en,
  input logic [CTR_W-1:0]   wr_ctr,
  input logic [SEL_W-1:0]   wr_sel,
  input logic               wr_err,
  input logic [EVT_W-1:0]   lk_evt,
  input logic               lk_hit,
  input logic [CTR_W-1:0]   lk_ctr
);
  AST_UNSUP_REJECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && (wr_sel != '0) && (evt_onehot(wr_sel[EVT_W-1:0]) == '0)) |=> wr_err); // R1

  AST_LOW_CTR_REJECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && (wr_ctr < CTR_W'(FIRST_PROG))) |=> wr_err); // R2

  AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_en |=> (!($stable(lk_evt) && $stable(avail_mask)) ||
                ($stable(lk_hit) && $stable(lk_ctr)))); // R3

  AST_ERR_ONLY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_en |=> !wr_err); // R7

  AST_CFG_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|avail_mask[FIRST_PROG-1:0]) |-> cfg_err); // R8

  AST_MASK_ZERO_MISS: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((avail_mask == '0) || cfg_err) |-> !lk_hit); // R9

  AST_UNKNOWN_MISS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (evt_onehot(lk_evt) == '0) |-> !lk_hit); // R11

  AST_HIT_PROG_CTR: assert property (@(posedge clk) disable iff (!rst_q_n)
    lk_hit |-> (lk_ctr >= CTR_W'(FIRST_PROG))); // R2
endmodule

bind evt_ctr_map evt_ctr_map_chk #(
  .NUM_CTR(NUM_CTR), .SEL_W(SEL_W), .FIRST_PROG(FIRST_PROG)
) u_chk (.*);

// File: tb/tb_evt_ctr_map.sv
module tb_evt_ctr_map;
  localparam int NUM_CTR = 32;
  localparam int SEL_W   = 32;
  localparam int CTR_W   = 5;
  localparam logic [31:0] MASK = 32'h0000_FFF8;

  logic               clk;
  logic               rst_n;
  logic [NUM_CTR-1:0] avail_mask;
  logic               cfg_err;
  logic               wr_en;
  logic [CTR_W-1:0]   wr_ctr;
  logic [SEL_W-1:0]   wr_sel;
  logic               wr_err;
  logic [19:0]        lk_evt;
  logic               lk_hit;
  logic [CTR_W-1:0]   lk_ctr;

  evt_ctr_map #(.NUM_CTR(NUM_CTR), .SEL_W(SEL_W)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {we, ctr[4:0], sel[31:0], lk[19:0], exp_err, exp_hit, exp_ctr[4:0]}
  localparam int NV = 18;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 5'd3,  32'h0000_0001, 20'h00001, 1'b0, 1'b1, 5'd3}, // R3 bind cycles
    {1'b1, 5'd4,  32'h0000_0001, 20'h00001, 1'b0, 1'b1, 5'd3}, // R4 first wins
    {1'b1, 5'd2,  32'h0000_0002, 20'h00002, 1'b1, 1'b0, 5'd0}, // R2 below 3
    {1'b1, 5'd20, 32'h0000_0002, 20'h00002, 1'b1, 1'b0, 5'd0}, // R2 not in mask
    {1'b1, 5'd4,  32'h0001_0019, 20'h10019, 1'b0, 1'b1, 5'd4}, // R3 dtlb rd
    {1'b1, 5'd4,  32'h0001_001B, 20'h1001B, 1'b0, 1'b1, 5'd4}, // R3 dtlb wr
    {1'b1, 5'd5,  32'hABC1_0021, 20'h10021, 1'b0, 1'b1, 5'd5}, // R6 upper bits
    {1'b1, 5'd5,  32'h0001_0020, 20'h10020, 1'b1, 1'b0, 5'd0}, // R1 unsupported
    {1'b1, 5'd5,  32'h0010_0000, 20'h10021, 1'b1, 1'b1, 5'd5}, // R6 index 0
    {1'b1, 5'd4,  32'h0000_0000, 20'h10019, 1'b0, 1'b0, 5'd0}, // R5 remove
    {1'b0, 5'd0,  32'h0000_0000, 20'h1001B, 1'b0, 1'b0, 5'd0}, // R5 both gone
    {1'b0, 5'd0,  32'h0000_0000, 20'h10021, 1'b0, 1'b1, 5'd5}, // R5 others kept
    {1'b0, 5'd0,  32'h0000_0000, 20'h00001, 1'b0, 1'b1, 5'd3}, // R5 others kept
    {1'b1, 5'd6,  32'h0000_0002, 20'h00002, 1'b0, 1'b1, 5'd6}, // R3 instr
    {1'b1, 5'd3,  32'h0000_0000, 20'h00001, 1'b0, 1'b0, 5'd0}, // R5 remove
    {1'b0, 5'd0,  32'h0000_0000, 20'h00003, 1'b0, 1'b0, 5'd0}, // R11 unknown
    {1'b1, 5'd31, 32'h0000_0001, 20'h00001, 1'b1, 1'b0, 5'd0}, // R2 mask bit 31
    {1'b1, 5'd7,  32'h0000_0000, 20'h00002, 1'b0, 1'b1, 5'd6}  // R5 empty clear
  };

  initial begin
    rst_n      = 1'b0;
    avail_mask = MASK;
    wr_en      = 1'b0;
    wr_ctr     = '0;
    wr_sel     = '0;
    lk_evt     = 20'h00001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R10 reset state
    chk("R10", "lk_hit after reset", 32'(lk_hit), 32'd0);
    chk("R10", "wr_err after reset", 32'(wr_err), 32'd0);
    chk("R8",  "cfg_err legal mask", 32'(cfg_err), 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr_en  = VEC[i][64];
      wr_ctr = VEC[i][63:59];
      wr_sel = VEC[i][58:27];
      lk_evt = VEC[i][26:7];
      step();
      chk("R1-7 vector", $sformatf("wr_err v%0d", i), 32'(wr_err), 32'(VEC[i][6]));
      chk("R3 vector", $sformatf("lk_hit v%0d", i), 32'(lk_hit), 32'(VEC[i][5]));
      if (VEC[i][5]) chk("R3 vector", $sformatf("lk_ctr v%0d", i), 32'(lk_ctr), 32'(VEC[i][4:0]));
      wr_en = 1'b0;
    end

    // R7 pulse lasts one cycle
    wr_en = 1'b1; wr_ctr = 5'd2; wr_sel = 32'h2;
    step();
    wr_en = 1'b0;
    chk("R7", "err pulse high", 32'(wr_err), 32'd1);
    step();
    chk("R7", "err pulse ends", 32'(wr_err), 32'd0);

    // R9 zero mask hides but keeps bindings
    lk_evt = 20'h00002;
    avail_mask = '0;
    #1;
    chk("R9", "zero mask miss", 32'(lk_hit), 32'd0);
    step();
    avail_mask = MASK;
    #1;
    chk("R9", "binding back hit", 32'(lk_hit), 32'd1);
    chk("R9", "binding back ctr", 32'(lk_ctr), 32'd6);

    // R8 illegal mask
    avail_mask = 32'hFFFF_FFFF;
    #1;
    chk("R8", "cfg_err low bits", 32'(cfg_err), 32'd1);
    chk("R8", "illegal mask miss", 32'(lk_hit), 32'd0);
    @(negedge clk);
    wr_en = 1'b1; wr_ctr = 5'd8; wr_sel = 32'h0001_0019;
    step();
    wr_en = 1'b0;
    chk("R8", "write rejected", 32'(wr_err), 32'd1);
    avail_mask = MASK;
    lk_evt = 20'h10019;
    #1;
    chk("R8", "no binding made", 32'(lk_hit), 32'd0);

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    lk_evt = 20'h10021;
    #1;
    chk("R10", "itlb cleared", 32'(lk_hit), 32'd0);
    lk_evt = 20'h00002;
    #1;
    chk("R10", "instr cleared", 32'(lk_hit), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule